// File: doc/BRIEF.md
# Card Bus Byte-Lane Access Decoder

This block sits behind the host-facing pins of a removable storage card whose parallel bus runs memory cycles (output-enable and write-enable strobes) and I/O cycles (separate I/O read and write strobes). Two active-low card enables and address bit 0 are decoded into a lane selection. A 16-bit host moves whole words. An 8-bit host can still reach every byte through the low eight data lines, because the first enable alone with address bit 0 set steers the odd byte down to the low lane. The register-select line chooses between the common space, which is a small 16-bit register file, and the attribute space, which is byte-wide at even addresses. The attribute space holds a read-only block of card information bytes followed by a few writable configuration bytes. I/O cycles reach the same register file as common memory.

A five-state machine tracks the host cycle. The states are IDLE, MEM_RD, MEM_WR, IO_RD and IO_WR. From IDLE, when at least one enable is low, the machine takes the first match in this priority order: I/O write strobe with register-select low goes to IO_WR, I/O read strobe with register-select low goes to IO_RD, write enable goes to MEM_WR, and output enable goes to MEM_RD. MEM_RD and IO_RD return to IDLE as soon as their strobe or the card enables are released. MEM_WR and IO_WR have two exits to IDLE. The "commit" exit is taken when the strobe rises, and the write is performed. The "abandon" exit is taken when the enables are released (and, for IO_WR, when register-select rises) while the strobe is still low, and nothing is written. In a write state, address, lanes and data are latched on every cycle the strobe is low, so the value stored is the one present at the trailing edge.

Top module: `cbl_access_decoder`

## Requirements
- R1: After reset `rd_oe` is 00, `inpack_n` and `iois16_n` are 1, `rd_data` is 0, and every register-file word and configuration byte reads back as zero.
- R2: With both enables low the access is a word: `rd_data[7:0]` is the even byte, `rd_data[15:8]` the odd byte, and `rd_oe` is 11. A write stores both bytes.
- R3: With only `ce1_n` low and `addr[0]`=0, the even byte uses lane 0 (`rd_data[7:0]`, `rd_oe`=01, `rd_data[15:8]`=0). A write stores only the even byte, from `wr_data[7:0]`.
- R4: With only `ce1_n` low and `addr[0]`=1, the odd byte uses lane 0: it reads on `rd_data[7:0]` with `rd_oe`=01, and a write stores `wr_data[7:0]` into the odd byte.
- R5: With only `ce2_n` low, the odd byte uses lane 1: it reads on `rd_data[15:8]` with `rd_oe`=10, and a write stores `wr_data[15:8]` into the odd byte.
- R6: With both enables high there is no access: `rd_oe`=00, `rd_data`=0, and a write strobe changes nothing.
- R7: `reg_n`=1 selects common memory, a register file of DEPTH (16) words at word index `addr[10:1]`. I/O cycles need `reg_n`=0 and reach the same register file. Reads at an index of DEPTH or above return 0.
- R8: In attribute space (`reg_n`=0 on memory cycles), byte k of the information block sits at address 2k for k<256, holds the value k XOR 0xC3, and ignores writes. The configuration bytes sit at 0x200+2j for j<4, are writable through the even byte, and reset to 0. The odd byte of any attribute address reads 0.
- R9: A write takes effect at the rising edge of its strobe, using the data sampled on the last clock edge the strobe was low. If the enables are released before the strobe rises, the write is abandoned.
- R10: `rd_oe` is non-zero only while the card is selected and the read strobe is low, starting from the first rising clock edge that sees the strobe low. It drops as soon as the strobe is released.
- R11: `inpack_n` is low only during an I/O read of a register-file index below DEPTH with the card selected.
- R12: `iois16_n` is low, with no clock delay, whenever the card is selected, `reg_n` is 0 and the address falls inside the register-file range.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ce1_n | input | 1 | First card enable, active low |
| ce2_n | input | 1 | Second card enable (odd byte), active low |
| addr | input | 11 | Host byte address |
| reg_n | input | 1 | 1 = common space, 0 = attribute space or I/O |
| oe_n | input | 1 | Memory read strobe, active low |
| we_n | input | 1 | Memory write strobe, active low |
| iord_n | input | 1 | I/O read strobe, active low |
| iowr_n | input | 1 | I/O write strobe, active low |
| wr_data | input | 16 | Data from the host bus |
| rd_data | output | 16 | Data toward the host bus (0 on disabled lanes) |
| rd_oe | output | 2 | Per-lane output enable: bit 0 low lane, bit 1 high lane |
| inpack_n | output | 1 | Input acknowledge for I/O reads, active low |
| iois16_n | output | 1 | Addressed port accepts 16-bit or odd-byte access, active low |

## Verification
Read data and lane enables are due after exactly one rising edge following the assertion of the read strobe. The bench drives on falling edges and samples at the next falling edge, and it also confirms that the enables are still off before that edge. A write lands on the rising edge at which the released strobe is first seen, so every read-back begins only after that edge. `iois16_n` and the release of `rd_oe` are combinational, so the bench checks them one nanosecond after changing the inputs, with no clock edge in between.

// File: rtl/cbl_pkg.sv
package cbl_pkg;

    typedef enum logic [2:0] {
        LANE_NONE,
        LANE_WORD,
        LANE_EVEN_LO,
        LANE_ODD_LO,
        LANE_ODD_HI
    } lane_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_MEM_RD,
        ST_MEM_WR,
        ST_IO_RD,
        ST_IO_WR
    } state_e;

    // content of the read-only information block, byte k
    function automatic logic [7:0] info_byte(input logic [7:0] k);
        return k ^ 8'hC3;
    endfunction

endpackage

// File: rtl/cbl_lane_decode.sv
module cbl_lane_decode
    import cbl_pkg::*;
(
    input  logic  ce1_n,
    input  logic  ce2_n,
    input  logic  a0,
    output lane_e lane
);

    always_comb begin
        unique case ({ce1_n, ce2_n})
            2'b00:   lane = LANE_WORD;
            2'b01:   lane = a0 ? LANE_ODD_LO : LANE_EVEN_LO;
            2'b10:   lane = LANE_ODD_HI;
            default: lane = LANE_NONE;
        endcase
    end

endmodule

// File: rtl/cbl_regfile.sv
module cbl_regfile #(
    parameter int DEPTH = 16,
    parameter int IW    = 10
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [IW-1:0] rd_idx,
    output logic [15:0]   rd_word,
    output logic          rd_hit,
    input  logic          wr_en,
    input  logic [IW-1:0] wr_idx,
    input  logic [1:0]    wr_be,
    input  logic [15:0]   wr_word
);

    localparam logic [IW-1:0] LIMIT = IW'(DEPTH);

    logic [15:0] mem [DEPTH];

    assign rd_hit = (rd_idx < LIMIT);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int j = 0; j < DEPTH; j++) mem[j] <= '0;
        end else if (wr_en) begin
            for (int j = 0; j < DEPTH; j++) begin
                if (wr_idx == IW'(j)) begin
                    if (wr_be[0]) mem[j][7:0]  <= wr_word[7:0];
                    if (wr_be[1]) mem[j][15:8] <= wr_word[15:8];
                end
            end
        end
    end

    always_comb begin
        rd_word = '0;
        for (int j = 0; j < DEPTH; j++) begin
            if (rd_idx == IW'(j)) rd_word = mem[j];
        end
    end

endmodule

// File: rtl/cbl_attr_mem.sv
module cbl_attr_mem
    import cbl_pkg::*;
#(
    parameter int             AW        = 11,
    parameter int             INFO_LEN  = 256,
    parameter int             CFG_NUM   = 4,
    parameter logic [AW-1:0]  CFG_BASE  = 11'h200
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] rd_addr,
    output logic [7:0]    rd_byte,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  logic [7:0]    wr_byte
);

    localparam logic [AW-1:0] INFO_END = AW'(2 * INFO_LEN);
    localparam logic [AW-1:0] CFG_END  = CFG_BASE + AW'(2 * CFG_NUM);

    function automatic logic cfg_slot(input logic [AW-1:0] a, input int j);
        logic [AW-1:0] off;
        off = a - CFG_BASE;
        return !a[0] && (a >= CFG_BASE) && (a < CFG_END) &&
               (off[AW-1:1] == (AW-1)'(j));
    endfunction

    logic [7:0] cfg_q [CFG_NUM];

    for (genvar g = 0; g < CFG_NUM; g++) begin : g_cfg
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                cfg_q[g] <= '0;
            else if (wr_en && cfg_slot(wr_addr, g))
                cfg_q[g] <= wr_byte;
        end
    end

    logic          info_hit;
    logic [AW-2:0] half;

    assign half     = rd_addr[AW-1:1];
    assign info_hit = !rd_addr[0] && (rd_addr < INFO_END);

    always_comb begin
        rd_byte = '0;
        if (info_hit) begin
            rd_byte = info_byte(half[7:0]);
        end else begin
            for (int j = 0; j < CFG_NUM; j++) begin
                if (cfg_slot(rd_addr, j)) rd_byte = cfg_q[j];
            end
        end
    end

endmodule

// File: rtl/cbl_access_decoder.sv
module cbl_access_decoder
    import cbl_pkg::*;
#(
    parameter int             AW       = 11,
    parameter int             DEPTH    = 16,
    parameter int             INFO_LEN = 256,
    parameter int             CFG_NUM  = 4,
    parameter logic [AW-1:0]  CFG_BASE = 11'h200
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ce1_n,
    input  logic          ce2_n,
    input  logic [AW-1:0] addr,
    input  logic          reg_n,
    input  logic          oe_n,
    input  logic          we_n,
    input  logic          iord_n,
    input  logic          iowr_n,
    input  logic [15:0]   wr_data,
    output logic [15:0]   rd_data,
    output logic [1:0]    rd_oe,
    output logic          inpack_n,
    output logic          iois16_n
);

    localparam int IW = AW - 1;

    state_e        state, state_nx;
    lane_e         lane;
    logic          sel;
    logic [IW-1:0] idx;

    assign sel = !ce1_n || !ce2_n;
    assign idx = addr[AW-1:1];

    cbl_lane_decode u_lane (
        .ce1_n (ce1_n),
        .ce2_n (ce2_n),
        .a0    (addr[0]),
        .lane  (lane)
    );

    // write steering from the current lane
    logic [1:0]  st_be;
    logic [15:0] st_word;

    always_comb begin
        unique case (lane)
            LANE_WORD:    begin st_be = 2'b11; st_word = wr_data;                    end
            LANE_EVEN_LO: begin st_be = 2'b01; st_word = {8'h00, wr_data[7:0]};      end
            LANE_ODD_LO:  begin st_be = 2'b10; st_word = {wr_data[7:0], 8'h00};      end
            LANE_ODD_HI:  begin st_be = 2'b10; st_word = {wr_data[15:8], 8'h00};     end
            default:      begin st_be = 2'b00; st_word = '0;                         end
        endcase
    end

    // next-state logic
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE: begin
                if (sel && !reg_n && !iowr_n)      state_nx = ST_IO_WR;
                else if (sel && !reg_n && !iord_n) state_nx = ST_IO_RD;
                else if (sel && !we_n)             state_nx = ST_MEM_WR;
                else if (sel && !oe_n)             state_nx = ST_MEM_RD;
            end
            ST_MEM_RD: if (oe_n || !sel)            state_nx = ST_IDLE;
            ST_IO_RD:  if (iord_n || !sel)          state_nx = ST_IDLE;
            ST_MEM_WR: if (we_n || !sel)            state_nx = ST_IDLE;
            ST_IO_WR:  if (iowr_n || !sel || reg_n) state_nx = ST_IDLE;
            default:                                state_nx = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    // write latch: follows the bus while the write strobe is low
    logic          wl_attr;
    logic [IW-1:0] wl_idx;
    logic [1:0]    wl_be;
    logic [15:0]   wl_word;
    logic          capture;

    assign capture = (state_nx == ST_MEM_WR) || (state_nx == ST_IO_WR);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wl_attr <= 1'b0;
            wl_idx  <= '0;
            wl_be   <= '0;
            wl_word <= '0;
        end else if (capture) begin
            wl_attr <= (state_nx == ST_MEM_WR) && !reg_n;
            wl_idx  <= idx;
            wl_be   <= st_be;
            wl_word <= st_word;
        end
    end

    // storage
    logic [15:0] rf_word;
    logic        rf_hit;
    logic [7:0]  attr_byte;
    logic        commit;

    cbl_regfile #(.DEPTH(DEPTH), .IW(IW)) u_rf (
        .clk     (clk),
        .rst_n   (rst_n),
        .rd_idx  (idx),
        .rd_word (rf_word),
        .rd_hit  (rf_hit),
        .wr_en   (commit && !wl_attr),
        .wr_idx  (wl_idx),
        .wr_be   (wl_be),
        .wr_word (wl_word)
    );

    cbl_attr_mem #(
        .AW(AW), .INFO_LEN(INFO_LEN), .CFG_NUM(CFG_NUM), .CFG_BASE(CFG_BASE)
    ) u_attr (
        .clk     (clk),
        .rst_n   (rst_n),
        .rd_addr ({idx, 1'b0}),
        .rd_byte (attr_byte),
        .wr_en   (commit && wl_attr && wl_be[0]),
        .wr_addr ({wl_idx, 1'b0}),
        .wr_byte (wl_word[7:0])
    );

    // output logic
    logic       rd_live;
    logic       attr_rd;
    logic [7:0] even_b, odd_b;

    always_comb begin
        commit   = 1'b0;
        rd_live  = 1'b0;
        attr_rd  = 1'b0;
        inpack_n = 1'b1;
        unique case (state)
            ST_IDLE: ;
            ST_MEM_RD: begin
                rd_live = sel && !oe_n;
                attr_rd = !reg_n;
            end
            ST_IO_RD: begin
                rd_live  = sel && !iord_n;
                inpack_n = !(sel && !iord_n && !reg_n && rf_hit);
            end
            ST_MEM_WR: commit = we_n;
            ST_IO_WR:  commit = iowr_n;
            default: ;
        endcase

        even_b = attr_rd ? attr_byte : rf_word[7:0];
        odd_b  = attr_rd ? 8'h00     : rf_word[15:8];

        rd_oe   = 2'b00;
        rd_data = '0;
        if (rd_live) begin
            unique case (lane)
                LANE_WORD:    begin rd_oe = 2'b11; rd_data = {odd_b, even_b}; end
                LANE_EVEN_LO: begin rd_oe = 2'b01; rd_data = {8'h00, even_b}; end
                LANE_ODD_LO:  begin rd_oe = 2'b01; rd_data = {8'h00, odd_b};  end
                LANE_ODD_HI:  begin rd_oe = 2'b10; rd_data = {odd_b, 8'h00};  end
                default: ;
            endcase
        end

        iois16_n = !(sel && !reg_n && rf_hit);
    end

    // checks beside the logic
    a_r2_word_needs_both_enables: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_oe == 2'b11) |-> (!ce1_n && !ce2_n));

    a_r10_lanes_need_read_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_oe != 2'b00) |-> (sel && (!oe_n || !iord_n)));

    a_r11_ack_only_with_data: assert property (@(posedge clk) disable iff (!rst_n)
        !inpack_n |-> (rd_oe != 2'b00) && !iord_n);

    a_r12_port16_needs_attr_sel: assert property (@(posedge clk) disable iff (!rst_n)
        !iois16_n |-> !reg_n);

    a_r9_commit_after_low_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        commit |-> $past(!we_n || !iowr_n));

endmodule

// File: tb/cbl_access_decoder_test.sv
`timescale 1ns/1ps
module cbl_access_decoder_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ce1_n = 1'b1, ce2_n = 1'b1, reg_n = 1'b1;
    logic        oe_n = 1'b1, we_n = 1'b1, iord_n = 1'b1, iowr_n = 1'b1;
    logic [10:0] addr = '0;
    logic [15:0] wr_data = '0;
    logic [15:0] rd_data;
    logic [1:0]  rd_oe;
    logic        inpack_n, iois16_n;

    int total = 0;
    int bad   = 0;

    always #2.5 clk = ~clk;

    cbl_access_decoder uut (
        .clk(clk), .rst_n(rst_n), .ce1_n(ce1_n), .ce2_n(ce2_n), .addr(addr),
        .reg_n(reg_n), .oe_n(oe_n), .we_n(we_n), .iord_n(iord_n), .iowr_n(iowr_n),
        .wr_data(wr_data), .rd_data(rd_data), .rd_oe(rd_oe),
        .inpack_n(inpack_n), .iois16_n(iois16_n)
    );

    // kind: 0 memory write, 1 memory read, 2 I/O write, 3 I/O read
    typedef struct packed {
        logic [1:0]  kind;
        logic        rg;
        logic        c1;
        logic        c2;
        logic [10:0] ad;
        logic [15:0] wd;
        logic [15:0] exp_d;
        logic [1:0]  exp_oe;
        logic        exp_ack;
        logic [3:0]  req;
    } vec_t;

    localparam int NV = 27;
    localparam vec_t VECS [0:NV-1] = '{
        '{2'd1,1'b1,1'b0,1'b0,11'h000,16'h0000,16'h0000,2'b11,1'b1,4'd1},  // R1 common reset
        '{2'd1,1'b0,1'b0,1'b1,11'h204,16'h0000,16'h0000,2'b01,1'b1,4'd1},  // R1 cfg reset
        '{2'd0,1'b1,1'b0,1'b0,11'h004,16'hBEEF,16'h0000,2'b00,1'b1,4'd2},  // R2 word write
        '{2'd1,1'b1,1'b0,1'b0,11'h004,16'h0000,16'hBEEF,2'b11,1'b1,4'd2},  // R2
        '{2'd1,1'b1,1'b0,1'b1,11'h004,16'h0000,16'h00EF,2'b01,1'b1,4'd3},  // R3
        '{2'd1,1'b1,1'b0,1'b1,11'h005,16'h0000,16'h00BE,2'b01,1'b1,4'd4},  // R4
        '{2'd1,1'b1,1'b1,1'b0,11'h004,16'h0000,16'hBE00,2'b10,1'b1,4'd5},  // R5
        '{2'd0,1'b1,1'b0,1'b1,11'h006,16'h1234,16'h0000,2'b00,1'b1,4'd3},  // R3 even write
        '{2'd0,1'b1,1'b0,1'b1,11'h007,16'hFF56,16'h0000,2'b00,1'b1,4'd4},  // R4 odd low write
        '{2'd1,1'b1,1'b0,1'b0,11'h006,16'h0000,16'h5634,2'b11,1'b1,4'd4},  // R4
        '{2'd0,1'b1,1'b1,1'b0,11'h006,16'h9A00,16'h0000,2'b00,1'b1,4'd5},  // R5 odd high write
        '{2'd1,1'b1,1'b0,1'b0,11'h006,16'h0000,16'h9A34,2'b11,1'b1,4'd5},  // R5
        '{2'd0,1'b1,1'b1,1'b1,11'h006,16'hFFFF,16'h0000,2'b00,1'b1,4'd6},  // R6 unselected write
        '{2'd1,1'b1,1'b0,1'b0,11'h006,16'h0000,16'h9A34,2'b11,1'b1,4'd6},  // R6
        '{2'd1,1'b1,1'b1,1'b1,11'h006,16'h0000,16'h0000,2'b00,1'b1,4'd6},  // R6 unselected read
        '{2'd2,1'b0,1'b0,1'b0,11'h008,16'hCAFE,16'h0000,2'b00,1'b1,4'd7},  // R7 I/O write
        '{2'd3,1'b0,1'b0,1'b0,11'h008,16'h0000,16'hCAFE,2'b11,1'b0,4'd11}, // R11 ack
        '{2'd1,1'b1,1'b0,1'b0,11'h008,16'h0000,16'hCAFE,2'b11,1'b1,4'd7},  // R7 shared file
        '{2'd1,1'b1,1'b0,1'b0,11'h040,16'h0000,16'h0000,2'b11,1'b1,4'd7},  // R7 out of range
        '{2'd3,1'b0,1'b0,1'b0,11'h040,16'h0000,16'h0000,2'b11,1'b1,4'd11}, // R11 no ack
        '{2'd1,1'b0,1'b0,1'b0,11'h000,16'h0000,16'h00C3,2'b11,1'b1,4'd8},  // R8 info 0
        '{2'd1,1'b0,1'b0,1'b1,11'h00A,16'h0000,16'h00C6,2'b01,1'b1,4'd8},  // R8 info 5
        '{2'd1,1'b0,1'b0,1'b1,11'h00B,16'h0000,16'h0000,2'b01,1'b1,4'd8},  // R8 odd attr
        '{2'd0,1'b0,1'b0,1'b1,11'h202,16'h0077,16'h0000,2'b00,1'b1,4'd8},  // R8 cfg write
        '{2'd1,1'b0,1'b0,1'b0,11'h202,16'h0000,16'h0077,2'b11,1'b1,4'd8},  // R8
        '{2'd0,1'b0,1'b0,1'b1,11'h004,16'h0011,16'h0000,2'b00,1'b1,4'd8},  // R8 info write
        '{2'd1,1'b0,1'b0,1'b1,11'h004,16'h0000,16'h00C1,2'b01,1'b1,4'd8}   // R8 unchanged
    };

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic release_bus();
        ce1_n = 1'b1; ce2_n = 1'b1; reg_n = 1'b1;
        oe_n = 1'b1; we_n = 1'b1; iord_n = 1'b1; iowr_n = 1'b1;
    endtask

    task automatic run_vec(input vec_t v);
        @(negedge clk);
        ce1_n = v.c1; ce2_n = v.c2; reg_n = v.rg; addr = v.ad; wr_data = v.wd;
        case (v.kind)
            2'd0: we_n   = 1'b0;
            2'd1: oe_n   = 1'b0;
            2'd2: iowr_n = 1'b0;
            default: iord_n = 1'b0;
        endcase
        @(negedge clk);
        if (v.kind == 2'd1 || v.kind == 2'd3)
            check($sformatf("R%0d vec addr=%h", v.req, v.ad),
                  {13'b0, rd_data, rd_oe, inpack_n},
                  {13'b0, v.exp_d, v.exp_oe, v.exp_ack});
        oe_n = 1'b1; we_n = 1'b1; iord_n = 1'b1; iowr_n = 1'b1;
        @(negedge clk);
        release_bus();
    endtask

    task automatic word_read(input logic [10:0] a, output logic [15:0] d);
        @(negedge clk);
        ce1_n = 1'b0; ce2_n = 1'b0; reg_n = 1'b1; addr = a; oe_n = 1'b0;
        @(negedge clk);
        d = rd_data;
        release_bus();
        @(negedge clk);
    endtask

    initial begin
        #20000;
        bad++; total++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [15:0] d;
        repeat (3) @(negedge clk);
        // R1 reset outputs
        check("R1 reset outputs", {13'b0, rd_data, rd_oe, inpack_n, iois16_n},
              {13'b0, 16'h0000, 2'b00, 1'b1, 1'b1});
        rst_n = 1'b1;
        @(negedge clk);

        for (int i = 0; i < NV; i++) run_vec(VECS[i]);

        // R12 port width indication, combinational
        @(negedge clk);
        ce1_n = 1'b0; reg_n = 1'b0; addr = 11'h008; #1;
        check("R12 in-range port", {31'b0, iois16_n}, 32'd0);
        reg_n = 1'b1; #1;
        check("R12 common space", {31'b0, iois16_n}, 32'd1);
        reg_n = 1'b0; addr = 11'h040; #1;
        check("R12 out of range", {31'b0, iois16_n}, 32'd1);
        release_bus();

        // R9 data of the last low-strobe cycle is stored
        @(negedge clk);
        ce1_n = 1'b0; ce2_n = 1'b0; addr = 11'h00A; wr_data = 16'h1111; we_n = 1'b0;
        @(negedge clk);
        wr_data = 16'h2222;
        @(negedge clk);
        we_n = 1'b1;
        @(negedge clk);
        release_bus();
        word_read(11'h00A, d);
        check("R9 trailing-edge data", {16'b0, d}, {16'b0, 16'h2222});

        // R9 enables released before strobe: abandoned
        @(negedge clk);
        ce1_n = 1'b0; ce2_n = 1'b0; addr = 11'h00C; wr_data = 16'h5555; we_n = 1'b0;
        @(negedge clk);
        ce1_n = 1'b1; ce2_n = 1'b1;
        @(negedge clk);
        we_n = 1'b1;
        @(negedge clk);
        word_read(11'h00C, d);
        check("R9 abandoned write", {16'b0, d}, 32'd0);

        // R10 timing of the lane enables
        @(negedge clk);
        ce1_n = 1'b0; ce2_n = 1'b0; addr = 11'h004; oe_n = 1'b0; #1;
        check("R10 before first edge", {30'b0, rd_oe}, 32'd0);
        @(negedge clk);
        check("R10 after first edge", {30'b0, rd_oe}, 32'd3);
        oe_n = 1'b1; #1;
        check("R10 strobe released", {30'b0, rd_oe}, 32'd0);
        release_bus();
        @(negedge clk);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule